// File: doc/BRIEF.md
# Address-Space Access Router

This block sits between a load/store unit and the memory system. Every request carries an 8-bit space identifier along with a 32-bit address, a 4-bit byte mask, write data and a write flag. The identifier alone decides where the access goes: a bank of three control registers, the data arrays of an instruction cache and a data cache, an external memory port, or a cache invalidation. The router answers each request with a one-cycle done pulse, an error bit and read data.

Bit 0 of the control register enables caching. While it is set, a successful read in an instruction or data space also loads the whole word into the matching cache. Writes in those spaces go through to memory, and once memory accepts them without error the same bytes are merged into the cache. Each cache has one word per index, selected by address bits 7:2, and one valid bit per byte lane. A flush clears every valid bit of a cache in a single cycle. A store-barrier-pending flag is set from outside and cleared by any write that completes without error.

Top module: `asi_router`

## Requirements
- R1: After reset, req_ready is 1, resp_done, mem_valid and barrier_pending are 0, all three control registers read 0, and every valid bit of both caches is clear.
- R2: Space 2 holds the control registers: address 0 is the cache control register, address 8 the instruction-cache configuration register and address 12 the data-cache configuration register. Each is written as a full word and reads back what was written. Any other address returns an error and changes no register.
- R3: Spaces 1, 8, 9, 10, 11 and 28 use the memory port. mem_valid stays high with stable fields until mem_ready, and mem_addr is the request address zero-extended to 36 bits with bits 1:0 cleared. resp_done follows one cycle after the memory handshake, with resp_err equal to mem_err. req_ready is low while the memory access is outstanding.
- R4: Every other space is handled locally. resp_done comes one cycle after acceptance and no memory request is issued.
- R5: While control bit 0 is set, a read in space 8 or 9 that completes without error writes the returned word into the instruction cache with all four bytes valid, and a read in space 10 or 11 does the same for the data cache. With the bit clear, on a memory error, and in spaces 1 and 28, no cache changes.
- R6: A write in space 8 or 9 (instruction) or 10 or 11 (data) sends data and mask unchanged to memory. If memory reports no error, the masked bytes of that cache word are updated and marked valid. Mask bit 3 selects data bits 31:24, the byte at the lowest address, and bit 0 selects bits 7:0.
- R7: Space 13 accesses the instruction-cache data array directly and space 15 the data-cache array. A write stores the full word with all bytes valid and ignores the mask. A read returns the valid bytes with invalid bytes as 0, and returns an error when no byte is valid.
- R8: A write to the cache control register flushes the instruction cache when data bit 21 is 1 and the data cache when data bit 22 is 1.
- R9: A write in space 16 flushes the instruction cache, in space 17 the data cache, and in space 24 both. A read in these spaces returns an error and flushes nothing.
- R10: Spaces 0, 3 to 7, 12, 14, 18 to 23, 25 to 27 and 29 to 255 return an error, issue no memory request and change no state.
- R11: barrier_pending is set in the cycle after barrier_set is high. It is cleared by any write that completes without error. Reads and failed writes leave it unchanged, and barrier_set wins over a clear in the same cycle.
- R12: resp_rdata is 0 for every write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_asi | input | 8 | Address-space identifier |
| req_addr | input | 32 | Byte address |
| req_mask | input | 4 | Byte mask, bit 3 = lowest byte address |
| req_wdata | input | 32 | Write data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Error for the completed request |
| resp_rdata | output | 32 | Read data for the completed request |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts and answers this cycle |
| mem_write | output | 1 | Memory write |
| mem_addr | output | 36 | Word-aligned physical address |
| mem_mask | output | 4 | Byte mask to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_err | input | 1 | Memory error, valid with mem_ready |
| barrier_set | input | 1 | Raise the store-barrier-pending flag |
| barrier_pending | output | 1 | Store-barrier-pending flag |

## Verification
The assertions assume that memory presents mem_rdata and mem_err in the same cycle it raises mem_ready, and raises mem_ready only while mem_valid is high. They also assume the requester looks at the request fields only in the cycle of the req_valid/req_ready handshake. The bench memory model derives mem_ready from mem_valid after a programmable wait and signals an error whenever address bit 30 is set. The bench issues a new request only after the previous done pulse, so every check sees exactly one request in flight.

// File: rtl/asi_router.sv
module asi_router #(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_asi,
  input  logic [31:0] req_addr,
  input  logic [3:0]  req_mask,
  input  logic [31:0] req_wdata,
  output logic        resp_done,
  output logic        resp_err,
  output logic [31:0] resp_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [35:0] mem_addr,
  output logic [3:0]  mem_mask,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  input  logic        barrier_set,
  output logic        barrier_pending
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [7:0] SP_FORCE  = 8'd1;
  localparam logic [7:0] SP_SYS    = 8'd2;
  localparam logic [7:0] SP_IDATA  = 8'd13;
  localparam logic [7:0] SP_DDATA  = 8'd15;
  localparam logic [7:0] SP_FL_I   = 8'd16;
  localparam logic [7:0] SP_FL_D   = 8'd17;
  localparam logic [7:0] SP_FL_ALL = 8'd24;
  localparam logic [7:0] SP_BYPASS = 8'd28;

  function automatic logic [31:0] lanes(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  logic        busy, q_write;
  logic [7:0]  q_asi;
  logic [31:0] q_addr, q_wdata;
  logic [3:0]  q_mask;
  logic [31:0] ccr, iccr, dccr;
  logic        l_err;
  logic [31:0] l_rdata;
  logic [1:0][31:0] rd_dat;
  logic [1:0][3:0]  rd_vld;
  logic [1:0]  c_flush, c_direct, c_fill, c_wt;

  wire r_isp  = req_asi[7:1] == 7'd4;
  wire r_dsp  = req_asi[7:1] == 7'd5;
  wire q_isp  = q_asi[7:1] == 7'd4;
  wire q_dsp  = q_asi[7:1] == 7'd5;
  wire r_mem  = (req_asi == SP_FORCE) | r_isp | r_dsp | (req_asi == SP_BYPASS);
  wire accept = req_valid & ~busy;
  wire local_go = accept & ~r_mem;
  wire local_wr = local_go & req_write;
  wire mem_done = busy & mem_ready;
  wire mem_ok   = mem_done & ~mem_err;
  wire ccr_sel  = (req_asi == SP_SYS) && (req_addr == 32'd0);
  wire [IDX_W-1:0] r_idx = req_addr[IDX_W+1:2];
  wire [IDX_W-1:0] q_idx = q_addr[IDX_W+1:2];
  wire wr_ok = (local_wr & ~l_err) | (mem_ok & q_write);

  assign req_ready = ~busy;
  assign mem_valid = busy;
  assign mem_write = q_write;
  assign mem_addr  = {4'b0, q_addr[31:2], 2'b00};
  assign mem_mask  = q_mask;
  assign mem_wdata = q_wdata;

  assign c_flush[0] = local_wr & ((ccr_sel & req_wdata[21]) | (req_asi == SP_FL_I) | (req_asi == SP_FL_ALL));
  assign c_flush[1] = local_wr & ((ccr_sel & req_wdata[22]) | (req_asi == SP_FL_D) | (req_asi == SP_FL_ALL));
  assign c_direct[0] = local_wr & (req_asi == SP_IDATA);
  assign c_direct[1] = local_wr & (req_asi == SP_DDATA);
  assign c_fill[0] = mem_ok & ~q_write & q_isp & ccr[0];
  assign c_fill[1] = mem_ok & ~q_write & q_dsp & ccr[0];
  assign c_wt[0]   = mem_ok & q_write & q_isp;
  assign c_wt[1]   = mem_ok & q_write & q_dsp;

  for (genvar c = 0; c < 2; c++) begin : g_cache
    logic [31:0] dat [DEPTH];
    logic [3:0]  vld [DEPTH];
    assign rd_dat[c] = dat[r_idx];
    assign rd_vld[c] = vld[r_idx];

    always_ff @(posedge clk) begin
      if (!rst_n || c_flush[c]) begin
        for (int i = 0; i < DEPTH; i++) vld[i] <= 4'h0;
      end else if (c_direct[c]) begin
        vld[r_idx] <= 4'hF;
      end else if (c_fill[c]) begin
        vld[q_idx] <= 4'hF;
      end else if (c_wt[c]) begin
        vld[q_idx] <= vld[q_idx] | q_mask;
      end
    end

    always_ff @(posedge clk) begin
      if (c_direct[c])   dat[r_idx] <= req_wdata;
      else if (c_fill[c]) dat[q_idx] <= mem_rdata;
      else if (c_wt[c])   dat[q_idx] <= (dat[q_idx] & ~lanes(q_mask)) | (q_wdata & lanes(q_mask));
    end
  end

  always_comb begin
    l_err   = 1'b1;
    l_rdata = '0;
    case (req_asi)
      SP_SYS: begin
        l_err = 1'b0;
        case (req_addr)
          32'd0:   l_rdata = ccr;
          32'd8:   l_rdata = iccr;
          32'd12:  l_rdata = dccr;
          default: l_err = 1'b1;
        endcase
      end
      SP_IDATA, SP_DDATA: begin
        l_rdata = rd_dat[req_asi == SP_DDATA] & lanes(rd_vld[req_asi == SP_DDATA]);
        l_err   = ~req_write & (rd_vld[req_asi == SP_DDATA] == 4'h0);
      end
      SP_FL_I, SP_FL_D, SP_FL_ALL: l_err = ~req_write;
      default: l_err = 1'b1;
    endcase
    if (req_write) l_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      q_write <= 1'b0;
      q_asi <= '0;
      q_addr <= '0;
      q_mask <= '0;
      q_wdata <= '0;
      ccr <= '0;
      iccr <= '0;
      dccr <= '0;
      resp_done <= 1'b0;
      resp_err <= 1'b0;
      resp_rdata <= '0;
      barrier_pending <= 1'b0;
    end else begin
      resp_done <= local_go | mem_done;
      if (local_go) begin
        resp_err   <= l_err;
        resp_rdata <= l_rdata;
      end else if (mem_done) begin
        resp_err   <= mem_err;
        resp_rdata <= q_write ? 32'd0 : mem_rdata;
      end
      if (accept && r_mem) begin
        busy    <= 1'b1;
        q_write <= req_write;
        q_asi   <= req_asi;
        q_addr  <= req_addr;
        q_mask  <= req_mask;
        q_wdata <= req_wdata;
      end else if (mem_done) begin
        busy <= 1'b0;
      end
      if (local_wr && req_asi == SP_SYS) begin
        case (req_addr)
          32'd0:   ccr  <= req_wdata;
          32'd8:   iccr <= req_wdata;
          32'd12:  dccr <= req_wdata;
          default: ;
        endcase
      end
      barrier_pending <= barrier_set | (barrier_pending & ~wr_ok);
    end
  end
endmodule

// File: rtl/asi_router_chk.sv
module asi_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [7:0]  req_asi,
  input logic        resp_done,
  input logic        resp_err,
  input logic [31:0] resp_rdata,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [35:0] mem_addr,
  input logic [3:0]  mem_mask,
  input logic [31:0] mem_wdata,
  input logic        mem_err,
  input logic        barrier_set,
  input logic        barrier_pending
);
  wire go = req_valid && req_ready;
  wire mem_space = (req_asi == 8'd1) || (req_asi >= 8'd8 && req_asi <= 8'd11) || (req_asi == 8'd28);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_mask) && $stable(mem_wdata)); // R3
  AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00 && mem_addr[35:32] == 4'h0); // R3
  AST_MEM_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> resp_done && resp_err == $past(mem_err)); // R3
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R3
  AST_LOCAL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    go && !mem_space |=> resp_done && !mem_valid); // R4
  AST_FLUSH_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    go && !req_write && (req_asi == 8'd16 || req_asi == 8'd17 || req_asi == 8'd24) |=> resp_err); // R9
  AST_TAG_SPACE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    go && (req_asi == 8'd12 || req_asi == 8'd14 || req_asi == 8'd25 || req_asi == 8'd29) |=> resp_done && resp_err); // R10
  AST_BARRIER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    barrier_set |=> barrier_pending); // R11
  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    go && req_write && !mem_space |=> resp_rdata == 32'd0); // R12
endmodule

bind asi_router asi_router_chk chk_i (.*);

// File: tb/asi_router_tb_top.sv
module asi_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_asi = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        req_ready, resp_done, resp_err;
  logic [31:0] resp_rdata;
  logic        mem_valid, mem_ready, mem_write, mem_err;
  logic [35:0] mem_addr;
  logic [3:0]  mem_mask;
  logic [31:0] mem_wdata, mem_rdata;
  logic        barrier_set = 1'b0, barrier_pending;

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, hs_cnt = 0;
  logic [31:0] marr [64];
  logic [35:0] last_addr;
  logic [31:0] g_rd;
  logic        g_er;
  int          g_n;

  always #10 clk = ~clk;

  asi_router dut_i (.*);

  assign mem_ready = mem_valid && (wcnt >= lat);
  assign mem_rdata = marr[mem_addr[7:2]];
  assign mem_err   = mem_addr[30];

  always @(posedge clk) begin
    if (!mem_valid || mem_ready) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (mem_valid && mem_ready) begin
      hs_cnt <= hs_cnt + 1;
      last_addr <= mem_addr;
      if (mem_write && !mem_err)
        for (int b = 0; b < 4; b++)
          if (mem_mask[b]) marr[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rq(input logic w, input logic [7:0] asi, input logic [31:0] addr,
                    input logic [3:0] m, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_asi = asi; req_addr = addr; req_mask = m; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g_n = 1;
    while (!resp_done && g_n < 50) begin
      if (mem_valid && req_ready) chk("R3 ready low while busy", 1, 0);
      @(negedge clk);
      g_n++;
    end
    g_rd = resp_rdata;
    g_er = resp_err;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 resp_done", resp_done, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 barrier", barrier_pending, 0);
    rq(0, 2, 0, 4'hF, 0);
    chk("R1 ccr zero", g_rd, 0);
    rq(0, 15, 32'h0000_0020, 4'hF, 0);
    chk("R1 dcache empty", g_er, 1);
  endtask

  task automatic t_sysreg;
    rq(1, 2, 0, 4'h0, 32'h0000_0001);
    chk("R4 local latency", g_n, 1);
    rq(0, 2, 0, 4'hF, 0);
    chk("R2 ccr readback", g_rd, 32'h0000_0001);
    rq(1, 2, 8, 4'hF, 32'h1234_5678);
    rq(1, 2, 12, 4'hF, 32'h9ABC_DEF0);
    rq(0, 2, 8, 4'hF, 0);
    chk("R2 iccr readback", g_rd, 32'h1234_5678);
    rq(0, 2, 12, 4'hF, 0);
    chk("R2 dccr readback", g_rd, 32'h9ABC_DEF0);
    rq(1, 2, 4, 4'hF, 32'hFFFF_FFFF);
    chk("R2 bad addr write err", g_er, 1);
    rq(0, 2, 4, 4'hF, 0);
    chk("R2 bad addr read err", g_er, 1);
    rq(0, 2, 8, 4'hF, 0);
    chk("R2 iccr untouched", g_rd, 32'h1234_5678);
    rq(1, 2, 0, 4'hF, 32'h0);
  endtask

  task automatic t_mem;
    int hs0;
    lat = 3;
    hs0 = hs_cnt;
    rq(1, 28, 32'h0000_0013, 4'hF, 32'h5566_7788);
    chk("R3 mem latency", g_n, 5);
    chk("R3 word address", last_addr, 36'h0_0000_0010);
    chk("R12 write rdata", g_rd, 0);
    chk("R3 one handshake", hs_cnt - hs0, 1);
    lat = 0;
    rq(0, 1, 32'h0000_0011, 4'hF, 0);
    chk("R3 read data", g_rd, 32'h5566_7788);
    chk("R3 read no err", g_er, 0);
    chk("R3 zero-wait latency", g_n, 2);
    rq(0, 28, 32'h4000_0000, 4'hF, 0);
    chk("R3 mem err", g_er, 1);
    rq(1, 28, 32'h0000_0020, 4'hF, 32'hA1B2_C3D4);
    rq(1, 28, 32'h0000_0024, 4'hF, 32'h0BAD_CAFE);
  endtask

  task automatic t_fill;
    rq(0, 8, 32'h0000_0020, 4'hF, 0);
    chk("R5 read ok", g_rd, 32'hA1B2_C3D4);
    rq(0, 13, 32'h0000_0020, 4'hF, 0);
    chk("R5 no fill when disabled", g_er, 1);
    rq(1, 2, 0, 4'hF, 32'h0000_0001);
    rq(0, 9, 32'h0000_0020, 4'hF, 0);
    rq(0, 13, 32'h0000_0020, 4'hF, 0);
    chk("R5 icache filled", g_rd, 32'hA1B2_C3D4);
    rq(0, 15, 32'h0000_0020, 4'hF, 0);
    chk("R5 dcache not filled by ifetch", g_er, 1);
    rq(0, 10, 32'h0000_0020, 4'hF, 0);
    rq(0, 15, 32'h0000_0020, 4'hF, 0);
    chk("R5 dcache filled", g_rd, 32'hA1B2_C3D4);
    rq(0, 1, 32'h0000_0024, 4'hF, 0);
    rq(0, 15, 32'h0000_0024, 4'hF, 0);
    chk("R5 forced miss no fill", g_er, 1);
    rq(0, 11, 32'h4000_0028, 4'hF, 0);
    chk("R5 failed read err", g_er, 1);
    rq(0, 15, 32'h0000_0028, 4'hF, 0);
    chk("R5 failed read no fill", g_er, 1);
  endtask

  task automatic t_wt;
    rq(1, 17, 0, 4'h0, 0);
    rq(1, 11, 32'h0000_0030, 4'b1000, 32'h1122_3344);
    rq(0, 28, 32'h0000_0030, 4'hF, 0);
    chk("R6 memory big-endian lane", g_rd, 32'h1100_0000);
    rq(0, 15, 32'h0000_0030, 4'hF, 0);
    chk("R6 dcache masked update", g_rd, 32'h1100_0000);
    rq(1, 8, 32'h0000_0034, 4'b0001, 32'hAABB_CCDD);
    rq(0, 13, 32'h0000_0034, 4'hF, 0);
    chk("R6 icache masked update", g_rd, 32'h0000_00DD);
    rq(1, 10, 32'h4000_0038, 4'hF, 32'hFFFF_FFFF);
    chk("R6 failed write err", g_er, 1);
    rq(0, 15, 32'h0000_0038, 4'hF, 0);
    chk("R6 failed write no cache", g_er, 1);
  endtask

  task automatic t_direct;
    int hs0;
    hs0 = hs_cnt;
    rq(1, 15, 32'h0000_0040, 4'h0, 32'hCAFE_F00D);
    chk("R7 direct write ok", g_er, 0);
    chk("R12 direct write rdata", g_rd, 0);
    rq(0, 15, 32'h0000_0040, 4'h0, 0);
    chk("R7 direct read full word", g_rd, 32'hCAFE_F00D);
    chk("R4 no mem request", hs_cnt - hs0, 0);
    rq(0, 28, 32'h0000_0040, 4'hF, 0);
    chk("R7 memory untouched", g_rd, 0);
  endtask

  task automatic t_flush;
    rq(1, 13, 32'h0000_0040, 4'hF, 32'h1234_5678);
    rq(0, 16, 0, 4'hF, 0);
    chk("R9 flush-space read err", g_er, 1);
    rq(0, 13, 32'h0000_0040, 4'hF, 0);
    chk("R9 read does not flush", g_rd, 32'h1234_5678);
    rq(1, 16, 0, 4'hF, 0);
    chk("R9 flush write ok", g_er, 0);
    rq(0, 13, 32'h0000_0040, 4'hF, 0);
    chk("R9 icache flushed", g_er, 1);
    rq(0, 15, 32'h0000_0040, 4'hF, 0);
    chk("R9 dcache kept", g_rd, 32'hCAFE_F00D);
    rq(1, 13, 32'h0000_0040, 4'hF, 32'h1);
    rq(1, 24, 0, 4'hF, 0);
    rq(0, 13, 32'h0000_0040, 4'hF, 0);
    chk("R9 flush all icache", g_er, 1);
    rq(0, 15, 32'h0000_0040, 4'hF, 0);
    chk("R9 flush all dcache", g_er, 1);
    rq(1, 13, 32'h0000_0044, 4'hF, 32'h1);
    rq(1, 15, 32'h0000_0044, 4'hF, 32'h2);
    rq(1, 2, 0, 4'hF, 32'h0040_0001);
    rq(0, 15, 32'h0000_0044, 4'hF, 0);
    chk("R8 bit22 flushes dcache", g_er, 1);
    rq(0, 13, 32'h0000_0044, 4'hF, 0);
    chk("R8 bit22 keeps icache", g_rd, 32'h1);
    rq(0, 2, 0, 4'hF, 0);
    chk("R8 ccr stored", g_rd, 32'h0040_0001);
    rq(1, 2, 0, 4'hF, 32'h0020_0000);
    rq(0, 13, 32'h0000_0044, 4'hF, 0);
    chk("R8 bit21 flushes icache", g_er, 1);
  endtask

  task automatic t_unsup;
    int hs0;
    hs0 = hs_cnt;
    rq(0, 12, 0, 4'hF, 0);
    chk("R10 space 12", g_er, 1);
    rq(1, 14, 0, 4'hF, 0);
    chk("R10 space 14", g_er, 1);
    rq(0, 25, 0, 4'hF, 0);
    chk("R10 space 25", g_er, 1);
    rq(1, 0, 0, 4'hF, 32'hFFFF_FFFF);
    chk("R10 space 0", g_er, 1);
    rq(1, 200, 0, 4'hF, 32'hFFFF_FFFF);
    chk("R10 space 200", g_er, 1);
    chk("R10 no memory traffic", hs_cnt - hs0, 0);
    rq(0, 2, 0, 4'hF, 0);
    chk("R10 ccr unchanged", g_rd, 32'h0020_0000);
  endtask

  task automatic t_barrier;
    @(negedge clk); barrier_set = 1'b1;
    @(negedge clk); barrier_set = 1'b0;
    chk("R11 set", barrier_pending, 1);
    rq(0, 28, 32'h0000_0010, 4'hF, 0);
    chk("R11 read keeps", barrier_pending, 1);
    rq(1, 28, 32'h4000_0010, 4'hF, 0);
    chk("R11 failed write keeps", barrier_pending, 1);
    rq(1, 14, 0, 4'hF, 0);
    chk("R11 error write keeps", barrier_pending, 1);
    rq(1, 2, 8, 4'hF, 32'h7);
    chk("R11 local write clears", barrier_pending, 0);
    @(negedge clk); barrier_set = 1'b1;
    @(negedge clk); barrier_set = 1'b0;
    rq(1, 28, 32'h0000_0050, 4'hF, 32'h3);
    chk("R11 memory write clears", barrier_pending, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) marr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sysreg;
    t_mem;
    t_fill;
    t_wt;
    t_direct;
    t_flush;
    t_unsup;
    t_barrier;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule